// File: doc/BRIEF.md
# Operand Address Former

This unit turns the mode and address bits of a single-address instruction into a 15-bit operand address. A one-cycle `start` pulse captures the instruction's address syllable, the location counter and the index register. The unit first forms a primary address. That address is either the 9-bit field taken as an absolute word number, or the location counter plus the field as a signed offset. The index register may then be added to it. If the indirect bit is set, the unit reads one word from memory at the primary address through a request/acknowledge read port. The low fifteen bits of that word become the address, and the word's top bit asks for the index register to be added once more. When the address is final, the unit raises `done` for one cycle. Along with it come the location-counter step to use: 2 when the primary address is the word right after the instruction, otherwise 1.

For halfword accesses the effective address is a byte number. The unit then also returns the containing word number and which half of the word the byte lies in. An even byte sits in the upper half (data bits 15..8), an odd byte in the lower half (bits 7..0). The surrounding sequencer fetches the operand itself and advances the location counter.

Top module: `ea_unit`

## Requirements
- R1: After synchronous reset, `done`, `rd_req`, `ea`, `word_addr`, `lo_byte` and `lc_incr` are all 0.
- R2: With `syl[11]`=0, `syl[10]`=0 and `syl[9]`=0 (absolute mode), `ea` equals the zero-extended field `syl[8:0]`. `done` rises in the cycle right after the edge that accepted `start`, and no read is requested.
- R3: With `syl[10]`=1 (relative), the primary address is `loc` plus `syl[8:0]` sign-extended from bit 8, modulo 2^15.
- R4: With `syl[9]`=1 (indexed), `xreg` is added to the primary address, modulo 2^15, in both absolute and relative mode.
- R5: With `syl[11]`=1 (indirect), exactly one read is issued. `rd_addr` equals the primary address and stays stable while `rd_req` is held until `rd_ack`. `done` rises in the cycle after the edge where `rd_ack` was seen, and `ea` equals `rd_data[14:0]` when `rd_data[15]`=0.
- R6: In indirect mode with `rd_data[15]`=1 in the fetched word, `ea` equals `rd_data[14:0]` plus `xreg`, modulo 2^15.
- R7: `lc_incr` is 2 when the primary address (after pre-indexing) equals `loc`+1 modulo 2^15. Otherwise it is 1.
- R8: With `byte_op`=1, `word_addr` is `ea` shifted right by one, and `lo_byte` equals `ea[0]` (1 selects data bits 7..0, 0 selects bits 15..8). With `byte_op`=0, `word_addr` equals `ea` and `lo_byte` is 0.
- R9: Changes of `syl`, `loc`, `xreg` or `byte_op`, and further `start` pulses, that occur after `start` was accepted and before `done` do not alter the result.
- R10: `done` is high for exactly one cycle per accepted `start`. `ea` keeps its value in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin address formation (accepted when idle) |
| syl | input | 12 | Instruction bits 4..15: [11] indirect, [10] relative, [9] indexed, [8:0] field |
| loc | input | 15 | Location counter of the instruction |
| xreg | input | 15 | Index register value |
| byte_op | input | 1 | Treat the effective address as a byte number |
| rd_req | output | 1 | Indirect-word read request |
| rd_addr | output | 15 | Indirect-word read address |
| rd_ack | input | 1 | Read completes; `rd_data` valid |
| rd_data | input | 16 | Indirect word; [15] post-index flag, [14:0] address |
| done | output | 1 | One-cycle pulse: results valid |
| ea | output | 15 | Effective address |
| word_addr | output | 15 | Word number holding the operand |
| lo_byte | output | 1 | Byte lies in data bits 7..0 |
| lc_incr | output | 2 | Location-counter step (1 or 2) |

## Verification
The assertions take for granted that the memory side raises `rd_ack` only while `rd_req` is high and answers within bounded time. They also assume that `rd_data` is meaningful only in the acknowledge cycle. The stimulus keeps within this with a responder that acknowledges for a single cycle, only while a request is pending, after zero to two wait cycles. Its data is a fixed function of the address, so both values of the post-index flag occur. Between acceptance and `done`, the stimulus deliberately inverts all captured inputs and pulses `start` again, while the sweep crosses every mode combination with boundary fields, counters and index values.

// File: rtl/ea_unit_pkg.sv
package ea_unit_pkg;
    localparam int WORD_W  = 16;
    localparam int ADDR_W  = WORD_W - 1;
    localparam int FIELD_W = 9;
    localparam int SYL_W   = FIELD_W + 3;
    localparam int SEXT_W  = ADDR_W - FIELD_W;
    localparam int B_IND   = SYL_W - 1;
    localparam int B_REL   = SYL_W - 2;
    localparam int B_IDX   = SYL_W - 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SYL_W-1:0]  syl_t;

    typedef struct packed {
        logic ind;
        logic rel;
        logic idx;
    } mode_t;

    typedef struct packed {
        addr_t prim;
        mode_t mode;
        logic  byte_op;
        logic  skip;
    } req_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } state_t;

    function automatic mode_t decode_mode(syl_t s);
        mode_t m;
        m.ind = s[B_IND];
        m.rel = s[B_REL];
        m.idx = s[B_IDX];
        return m;
    endfunction

    function automatic addr_t field_signed(syl_t s);
        return {{SEXT_W{s[FIELD_W-1]}}, s[FIELD_W-1:0]};
    endfunction

    function automatic addr_t field_unsigned(syl_t s);
        return {{SEXT_W{1'b0}}, s[FIELD_W-1:0]};
    endfunction
endpackage

// File: rtl/ea_primary.sv
module ea_primary
    import ea_unit_pkg::*;
(
    input  syl_t  syl,
    input  addr_t loc,
    input  addr_t xreg,
    output mode_t mode,
    output addr_t prim,
    output logic  skip
);
    addr_t base;
    addr_t next_loc;

    always_comb begin
        mode     = decode_mode(syl);
        base     = mode.rel ? addr_t'(loc + field_signed(syl)) : field_unsigned(syl);
        prim     = mode.idx ? addr_t'(base + xreg) : base;
        next_loc = addr_t'(loc + addr_t'(1));
        skip     = (prim == next_loc);
    end
endmodule

// File: rtl/ea_post.sv
module ea_post
    import ea_unit_pkg::*;
(
    input  word_t ind_word,
    input  addr_t xreg_q,
    output addr_t addr
);
    always_comb begin
        addr = ind_word[ADDR_W-1:0];
        if (ind_word[WORD_W-1])
            addr = addr_t'(ind_word[ADDR_W-1:0] + xreg_q);
    end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import ea_unit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  req_t       req_in,
    input  addr_t      x_in,
    input  logic       rd_ack,
    input  addr_t      post_addr,
    output logic       rd_req,
    output addr_t      rd_addr,
    output addr_t      x_q,
    output logic       done,
    output addr_t      ea,
    output logic       byte_q,
    output logic [1:0] lc_incr
);
    state_t     state;
    req_t       req_q;
    addr_t      ea_q;
    logic [1:0] lc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            req_q <= '0;
            x_q   <= '0;
            ea_q  <= '0;
            lc_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        req_q <= req_in;
                        x_q   <= x_in;
                        lc_q  <= req_in.skip ? 2'd2 : 2'd1;
                        if (req_in.mode.ind) begin
                            state <= ST_FETCH;
                        end else begin
                            ea_q  <= req_in.prim;
                            state <= ST_DONE;
                        end
                    end
                end
                ST_FETCH: begin
                    if (rd_ack) begin
                        ea_q  <= post_addr;
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rd_req  = (state == ST_FETCH);
    assign rd_addr = req_q.prim;
    assign done    = (state == ST_DONE);
    assign ea      = ea_q;
    assign byte_q  = req_q.byte_op;
    assign lc_incr = lc_q;

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr) && !done));
    assert_ack_finishes_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_ack) |=> (done && !rd_req));
    assert_step_range_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (lc_incr == 2'd1 || lc_incr == 2'd2));
endmodule

// File: rtl/ea_byte.sv
module ea_byte
    import ea_unit_pkg::*;
(
    input  addr_t ea,
    input  logic  byte_q,
    output addr_t word_addr,
    output logic  lo_byte
);
    always_comb begin
        word_addr = byte_q ? addr_t'(ea >> 1) : ea;
        lo_byte   = byte_q & ea[0];
    end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_unit_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [11:0] syl,
    input  logic [14:0] loc,
    input  logic [14:0] xreg,
    input  logic        byte_op,
    output logic        rd_req,
    output logic [14:0] rd_addr,
    input  logic        rd_ack,
    input  logic [15:0] rd_data,
    output logic        done,
    output logic [14:0] ea,
    output logic [14:0] word_addr,
    output logic        lo_byte,
    output logic [1:0]  lc_incr
);
    mode_t mode_w;
    addr_t prim_w;
    logic  skip_w;
    req_t  req_w;
    addr_t post_w;
    addr_t x_q;
    logic  byte_q;

    ea_primary u_primary (
        .syl  (syl),
        .loc  (loc),
        .xreg (xreg),
        .mode (mode_w),
        .prim (prim_w),
        .skip (skip_w)
    );

    always_comb begin
        req_w.prim    = prim_w;
        req_w.mode    = mode_w;
        req_w.byte_op = byte_op;
        req_w.skip    = skip_w;
    end

    ea_post u_post (
        .ind_word (rd_data),
        .xreg_q   (x_q),
        .addr     (post_w)
    );

    ea_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_in    (req_w),
        .x_in      (xreg),
        .rd_ack    (rd_ack),
        .post_addr (post_w),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .x_q       (x_q),
        .done      (done),
        .ea        (ea),
        .byte_q    (byte_q),
        .lc_incr   (lc_incr)
    );

    ea_byte u_byte (
        .ea        (ea),
        .byte_q    (byte_q),
        .word_addr (word_addr),
        .lo_byte   (lo_byte)
    );

    assert_ea_hold_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(ea));
    assert_byte_half_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !byte_q) |-> (!lo_byte && word_addr == ea));
endmodule

// File: tb/ea_unit_bench.sv
module ea_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] syl = '0;
    logic [14:0] loc = '0;
    logic [14:0] xreg = '0;
    logic        byte_op = 1'b0;
    logic        rd_req;
    logic [14:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [15:0] rd_data = '0;
    logic        done;
    logic [14:0] ea;
    logic [14:0] word_addr;
    logic        lo_byte;
    logic [1:0]  lc_incr;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    ea_unit u_ea_unit (
        .clk(clk), .rst(rst), .start(start), .syl(syl), .loc(loc), .xreg(xreg),
        .byte_op(byte_op), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_data(rd_data), .done(done), .ea(ea), .word_addr(word_addr),
        .lo_byte(lo_byte), .lc_incr(lc_incr)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_word(input logic [14:0] a);
        logic [14:0] v;
        v = 15'(a * 15'd13 + 15'd5);
        return {a[2] ^ a[5], v};
    endfunction

    task automatic run_one(input logic [11:0] s, input logic [14:0] l,
                           input logic [14:0] x, input logic b, input int wt);
        logic [14:0] prim;
        logic [14:0] exp_ea;
        logic [14:0] exp_wa;
        logic [1:0]  exp_lc;
        logic [15:0] w;
        logic [14:0] held;
        bit ind;
        bit rel;
        bit idx;
        int n;
        int reads;
        int reqs;
        bit got;
        string rq;
        ind = s[11];
        rel = s[10];
        idx = s[9];
        prim = rel ? 15'(l + {{6{s[8]}}, s[8:0]}) : {6'b0, s[8:0]};
        if (idx) prim = 15'(prim + x);
        exp_lc = (prim == 15'(l + 15'd1)) ? 2'd2 : 2'd1;
        exp_ea = prim;
        rq = idx ? "R4" : (rel ? "R3" : "R2");
        if (ind) begin
            w = mem_word(prim);
            exp_ea = w[15] ? 15'(w[14:0] + x) : w[14:0];
            rq = w[15] ? "R6" : "R5";
        end
        exp_wa = b ? (exp_ea >> 1) : exp_ea;

        @(negedge clk);
        start = 1'b1; syl = s; loc = l; xreg = x; byte_op = b;
        @(negedge clk);
        // R9: scramble every captured input and pulse start while busy
        syl = ~s; loc = ~l; xreg = ~x; byte_op = ~b; start = 1'b1;
        n = 1; reads = 0; reqs = 0; got = 0;
        while (n < 30) begin
            rd_ack = 1'b0;
            if (done) begin
                got = 1;
                break;
            end
            if (rd_req) begin
                reqs = reqs + 1;
                chk(rd_addr == prim, "R5", "read address", 32'(rd_addr), 32'(prim));
                if (reqs == wt + 1) begin
                    rd_ack = 1'b1;
                    rd_data = mem_word(rd_addr);
                    reads = reads + 1;
                end
            end
            @(negedge clk);
            start = 1'b0;
            n = n + 1;
        end
        rd_ack = 1'b0;
        start = 1'b0;
        chk(got, "R10", "done seen", 32'(got), 32'd1);
        chk(n == (ind ? wt + 2 : 1), ind ? "R5" : "R2", "done latency",
            32'(n), 32'(ind ? wt + 2 : 1));
        chk(reads == (ind ? 1 : 0), ind ? "R5" : "R2", "read count",
            32'(reads), 32'(ind ? 1 : 0));
        chk(ea == exp_ea, rq, "effective address", 32'(ea), 32'(exp_ea));
        chk(lc_incr == exp_lc, "R7", "location step", 32'(lc_incr), 32'(exp_lc));
        chk(word_addr == exp_wa, "R8", "word address", 32'(word_addr), 32'(exp_wa));
        chk(lo_byte == (b & exp_ea[0]), "R8", "low byte select",
            32'(lo_byte), 32'(b & exp_ea[0]));
        chk(ea == exp_ea && word_addr == exp_wa, "R9", "result after busy changes",
            32'(ea), 32'(exp_ea));
        held = ea;
        @(negedge clk);
        chk(!done, "R10", "done single cycle", 32'(done), 32'd0);
        chk(ea == held, "R10", "address held", 32'(ea), 32'(held));
    endtask

    initial begin
        logic [8:0]  flds [6];
        logic [14:0] locs [3];
        logic [14:0] xs   [3];
        int k;
        flds[0] = 9'h000; flds[1] = 9'h001; flds[2] = 9'h0FF;
        flds[3] = 9'h100; flds[4] = 9'h1FF; flds[5] = 9'h0AA;
        locs[0] = 15'h0000; locs[1] = 15'h7FFF; locs[2] = 15'h1234;
        xs[0] = 15'h0000; xs[1] = 15'h7FFF; xs[2] = 15'h0456;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!done, "R1", "done after reset", 32'(done), 32'd0);
        chk(!rd_req, "R1", "rd_req after reset", 32'(rd_req), 32'd0);
        chk(ea == '0, "R1", "ea after reset", 32'(ea), 32'd0);
        chk(word_addr == '0 && !lo_byte, "R1", "byte outputs after reset",
            32'(word_addr), 32'd0);
        chk(lc_incr == 2'd0, "R1", "step after reset", 32'(lc_incr), 32'd0);
        k = 0;
        for (int m = 0; m < 8; m++) begin
            for (int f = 0; f < 6; f++) begin
                for (int li = 0; li < 3; li++) begin
                    for (int xi = 0; xi < 3; xi++) begin
                        run_one({m[2:0], flds[f]}, locs[li], xs[xi], k[0], k % 3);
                        k = k + 1;
                    end
                end
            end
        end
        // R7 skip corner: relative +1, and absolute field equal to loc+1
        run_one({3'b010, 9'h001}, 15'h0200, 15'h0000, 1'b0, 0);
        run_one({3'b000, 9'h001}, 15'h0000, 15'h0000, 1'b1, 1);
        run_one({3'b110, 9'h001}, 15'h7FFF, 15'h0000, 1'b0, 2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule